// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor with Media Autoselect

This block decides whether a twisted-pair link is alive and picks the medium that the node uses. The twisted-pair receiver reports two kinds of one-cycle strobes: decoded data activity and single link pulses. Each strobe carries a flag that marks inverted receive polarity. A link pulse counts only when it arrives no sooner than a minimum spacing after the link pulse before it. A pulse that comes earlier is treated as noise. Valid link pulses and data keep the link up. A long quiet period takes it down.

When the link is down, the attachment-unit path is enabled and the twisted-pair path is disabled. When the link is up, the opposite holds. A mode input can pin operation to twisted pair, in which case no link activity is needed. A separate polarity tracker reports that the receive pair is wired in reverse. It changes its verdict only after a run of consecutive valid events that all disagree with it. All timers count in milliseconds, using one prescaler that is shared by every timer.

Top module: `link_media_select`

## Requirements
- R1: When reset is released with `auto_sel` high, `link_fail` = 1, `aui_en` = 1, `tp_en` = 0 and `pol_reversed` = 0.
- R2: While `auto_sel` is low, `tp_en` = 1, `aui_en` = 0 and `link_fail` = 0, whatever the receive activity.
- R3: A link pulse that arrives less than GAP_MIN_MS ticks after the previous link pulse is discarded. It does not restore the link, does not restart the loss timer and does not count toward the polarity decision. The first link pulse after reset is always accepted.
- R4: In the failed state, a data strobe, or a link pulse spaced at least GAP_MIN_MS ticks after the previous one, makes `link_fail` low in the cycle after the strobe.
- R5: While the link is up in automatic mode, LOSS_MS ticks without an accepted pulse or a data strobe set `link_fail` high. Any accepted activity restarts that interval.
- R6: `tp_en` is always the inverse of `aui_en`, and `aui_en` equals `link_fail`.
- R7: With `pol_fix_en` high, `pol_reversed` toggles only after POL_CONFIRM consecutive accepted events whose polarity flag (1 = negative) differs from it. An accepted event that agrees with it clears the run. When a data strobe and a pulse occur in the same cycle, the flag of the data strobe is the one used.
- R8: While `pol_fix_en` is low, `pol_reversed` is held at 0 from the next cycle on, and events build no run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_sel | input | 1 | 1 = automatic media selection, 0 = twisted pair forced on |
| pol_fix_en | input | 1 | Enables polarity detection |
| data_evt | input | 1 | One-cycle strobe for decoded receive data activity |
| data_neg | input | 1 | Polarity of the data activity (1 = inverted) |
| pulse_evt | input | 1 | One-cycle strobe for a detected link pulse |
| pulse_neg | input | 1 | Polarity of the link pulse (1 = inverted) |
| link_fail | output | 1 | High while the link is judged down in automatic mode |
| pol_reversed | output | 1 | High when the receive pair is judged reversed |
| tp_en | output | 1 | Enables the twisted-pair transmit, receive and loopback path |
| aui_en | output | 1 | Enables the attachment-unit path |

## Verification
The assertions assume that every strobe is a clean single-cycle pulse sampled on the rising edge. They also assume that `auto_sel` and `pol_fix_en` change only between events. The noise-pulse property treats any spacing within (GAP_MIN_MS-1)*TICK_DIV cycles of the previous pulse as certainly rejected, because the shared prescaler leaves one tick of uncertainty. The stimulus changes inputs only on falling edges, holds each strobe for exactly one cycle, and chooses pulse spacings and quiet periods several cycles away from either edge of that uncertainty band. As a result, each expected outcome is exact.

// File: rtl/link_sel_pkg.sv
package link_sel_pkg;

    typedef enum logic {
        LS_DOWN = 1'b0,
        LS_UP   = 1'b1
    } link_state_t;

    // One accepted receive event with its polarity flag
    typedef struct packed {
        logic hit;
        logic neg;
    } rx_evt_t;

    // Merge data activity and accepted link pulse; data polarity wins
    function automatic rx_evt_t pick_evt(input logic d_hit, input logic d_neg,
                                         input logic p_hit, input logic p_neg);
        rx_evt_t e;
        e.hit = d_hit | p_hit;
        e.neg = d_hit ? d_neg : p_neg;
        return e;
    endfunction

endpackage

// File: rtl/link_sel_tick.sv
module link_sel_tick #(
    parameter int DIV = 20000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = $clog2(DIV + 1);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + W'(1);
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/link_sel_gap.sv
module link_sel_gap #(
    parameter int GAP_MIN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pulse_in,
    output logic pulse_ok
);
    localparam int W = $clog2(GAP_MIN + 1);
    localparam logic [W-1:0] SAT = W'(GAP_MIN);

    // Ticks since the last pulse, saturating; starts saturated so the
    // first pulse after reset is accepted
    logic [W-1:0] gap;

    assign pulse_ok = pulse_in && (gap == SAT);

    always_ff @(posedge clk) begin
        if (rst)                     gap <= SAT;
        else if (pulse_in)           gap <= '0;
        else if (tick && gap != SAT) gap <= gap + W'(1);
    end
endmodule

// File: rtl/link_sel_loss.sv
module link_sel_loss
    import link_sel_pkg::*;
#(
    parameter int LOSS = 85
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        force_up,
    input  logic        activity,
    output link_state_t state
);
    localparam int W = $clog2(LOSS + 1);
    localparam logic [W-1:0] LIM = W'(LOSS - 1);

    logic [W-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LS_DOWN;
            timer <= '0;
        end else if (force_up) begin
            state <= LS_UP;
            timer <= '0;
        end else begin
            case (state)
                LS_DOWN: begin
                    timer <= '0;
                    if (activity) state <= LS_UP;
                end
                default: begin
                    if (activity) begin
                        timer <= '0;
                    end else if (tick) begin
                        if (timer == LIM) begin
                            state <= LS_DOWN;
                            timer <= '0;
                        end else begin
                            timer <= timer + W'(1);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/link_sel_pol.sv
module link_sel_pol
    import link_sel_pkg::*;
#(
    parameter int CONFIRM = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  rx_evt_t evt,
    output logic    flag
);
    localparam int W = $clog2(CONFIRM + 1);
    localparam logic [W-1:0] LAST = W'(CONFIRM - 1);

    logic [W-1:0] streak;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            flag   <= 1'b0;
            streak <= '0;
        end else if (evt.hit) begin
            if (evt.neg != flag) begin
                if (streak == LAST) begin
                    flag   <= ~flag;
                    streak <= '0;
                end else begin
                    streak <= streak + W'(1);
                end
            end else begin
                streak <= '0;
            end
        end
    end
endmodule

// File: rtl/link_media_select.sv
module link_media_select
    import link_sel_pkg::*;
#(
    parameter int TICK_DIV    = 20000,
    parameter int GAP_MIN_MS  = 5,
    parameter int LOSS_MS     = 85,
    parameter int POL_CONFIRM = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic auto_sel,
    input  logic pol_fix_en,
    input  logic data_evt,
    input  logic data_neg,
    input  logic pulse_evt,
    input  logic pulse_neg,
    output logic link_fail,
    output logic pol_reversed,
    output logic tp_en,
    output logic aui_en
);
    logic        tick;
    logic        pulse_ok;
    rx_evt_t     evt;
    link_state_t st;

    link_sel_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    link_sel_gap #(.GAP_MIN(GAP_MIN_MS)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .pulse_in (pulse_evt),
        .pulse_ok (pulse_ok)
    );

    assign evt = pick_evt(data_evt, data_neg, pulse_ok, pulse_neg);

    link_sel_loss #(.LOSS(LOSS_MS)) u_loss (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .force_up (!auto_sel),
        .activity (evt.hit),
        .state    (st)
    );

    link_sel_pol #(.CONFIRM(POL_CONFIRM)) u_pol (
        .clk  (clk),
        .rst  (rst),
        .en   (pol_fix_en),
        .evt  (evt),
        .flag (pol_reversed)
    );

    assign link_fail = auto_sel && (st == LS_DOWN);
    assign aui_en    = link_fail;
    assign tp_en     = !link_fail;
endmodule

// File: rtl/link_media_select_chk.sv
module link_media_select_chk #(
    parameter int TICK_DIV    = 20000,
    parameter int GAP_MIN_MS  = 5,
    parameter int LOSS_MS     = 85,
    parameter int POL_CONFIRM = 2
) (
    input logic clk,
    input logic rst,
    input logic auto_sel,
    input logic pol_fix_en,
    input logic data_evt,
    input logic pulse_evt,
    input logic link_fail,
    input logic pol_reversed,
    input logic tp_en,
    input logic aui_en
);
    localparam int NOISE = (GAP_MIN_MS - 1) * TICK_DIV;
    localparam int CW = $clog2(NOISE + 2);
    localparam logic [CW-1:0] NOISE_V = CW'(NOISE);
    localparam logic [CW-1:0] SAT_V   = CW'(NOISE + 1);

    logic [CW-1:0] gap_cyc;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cyc <= '0;
            seen    <= 1'b0;
        end else if (pulse_evt) begin
            gap_cyc <= '0;
            seen    <= 1'b1;
        end else if (gap_cyc != SAT_V) begin
            gap_cyc <= gap_cyc + CW'(1);
        end
    end

    // R2
    forced_tp_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_sel |-> (tp_en && !aui_en && !link_fail));

    // R3
    noise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_evt && !data_evt && seen && gap_cyc <= NOISE_V && auto_sel && link_fail)
        |=> (link_fail || !auto_sel));

    // R4
    data_restores_chk: assert property (@(posedge clk) disable iff (rst)
        data_evt |=> (!link_fail || !auto_sel));

    // R5
    fail_after_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(link_fail) && $past(auto_sel)) |-> !$past(data_evt));

    // R7
    pol_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pol_reversed) && $past(pol_fix_en)) |-> $past(data_evt || pulse_evt));

    // R8
    pol_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !pol_fix_en |=> !pol_reversed);
endmodule

bind link_media_select link_media_select_chk #(
    .TICK_DIV    (TICK_DIV),
    .GAP_MIN_MS  (GAP_MIN_MS),
    .LOSS_MS     (LOSS_MS),
    .POL_CONFIRM (POL_CONFIRM)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .auto_sel     (auto_sel),
    .pol_fix_en   (pol_fix_en),
    .data_evt     (data_evt),
    .pulse_evt    (pulse_evt),
    .link_fail    (link_fail),
    .pol_reversed (pol_reversed),
    .tp_en        (tp_en),
    .aui_en       (aui_en)
);

// File: tb/link_media_select_test.sv
module link_media_select_test;
    // Scaled timing: tick = 4 cycles, spacing 5 ticks, loss 40 ticks
    localparam int DIV  = 4;
    localparam int GAP  = 5;
    localparam int LOSS = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic auto_sel = 1'b1;
    logic pol_fix_en = 1'b1;
    logic data_evt = 1'b0;
    logic data_neg = 1'b0;
    logic pulse_evt = 1'b0;
    logic pulse_neg = 1'b0;
    logic link_fail, pol_reversed, tp_en, aui_en;

    int total = 0;
    int miss = 0;

    always #5 clk = ~clk;

    link_media_select #(
        .TICK_DIV(DIV), .GAP_MIN_MS(GAP), .LOSS_MS(LOSS), .POL_CONFIRM(2)
    ) uut (
        .clk(clk), .rst(rst), .auto_sel(auto_sel), .pol_fix_en(pol_fix_en),
        .data_evt(data_evt), .data_neg(data_neg),
        .pulse_evt(pulse_evt), .pulse_neg(pulse_neg),
        .link_fail(link_fail), .pol_reversed(pol_reversed),
        .tp_en(tp_en), .aui_en(aui_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pulse(input logic neg);
        pulse_evt = 1'b1;
        pulse_neg = neg;
        @(negedge clk);
        pulse_evt = 1'b0;
        pulse_neg = 1'b0;
    endtask

    task automatic send_data(input logic neg);
        data_evt = 1'b1;
        data_neg = neg;
        @(negedge clk);
        data_evt = 1'b0;
        data_neg = 1'b0;
    endtask

    task automatic expect_link(input string tag, input logic fail);
        chk({tag, " link_fail"}, link_fail, fail);
        chk("R6 aui_en", aui_en, fail);
        chk("R6 tp_en", tp_en, !fail);
    endtask

    task automatic t_reset;
        idle(3);
        rst = 1'b0;
        idle(1);
        expect_link("R1", 1'b1);
        chk("R1 pol_reversed", pol_reversed, 1'b0);
    endtask

    task automatic t_first_pulse;
        send_pulse(1'b0);
        expect_link("R4 first pulse", 1'b0);
    endtask

    task automatic t_loss;
        idle(150);
        expect_link("R5 before limit", 1'b0);
        idle(15);
        expect_link("R5 after limit", 1'b1);
    endtask

    task automatic t_noise;
        send_pulse(1'b0);
        expect_link("R4 valid pulse", 1'b0);
        for (int i = 0; i < 11; i++) begin
            idle(14);
            send_pulse(1'b0);
        end
        expect_link("R3 noise stream", 1'b1);
        idle(29);
        send_pulse(1'b0);
        expect_link("R3 spaced pulse", 1'b0);
    endtask

    task automatic t_data;
        idle(170);
        expect_link("R5 quiet", 1'b1);
        send_data(1'b0);
        expect_link("R4 data", 1'b0);
        idle(100);
        send_data(1'b0);
        idle(100);
        expect_link("R5 restart", 1'b0);
        idle(70);
        expect_link("R5 second loss", 1'b1);
    endtask

    task automatic t_polarity;
        send_data(1'b1);
        chk("R7 single neg", pol_reversed, 1'b0);
        send_data(1'b0);
        send_data(1'b1);
        chk("R7 run cleared", pol_reversed, 1'b0);
        send_data(1'b1);
        chk("R7 two neg", pol_reversed, 1'b1);
        send_pulse(1'b0);
        chk("R7 single pos pulse", pol_reversed, 1'b1);
        idle(29);
        send_pulse(1'b0);
        chk("R7 two pos pulses", pol_reversed, 1'b0);
        idle(29);
        send_pulse(1'b1);
        idle(9);
        send_pulse(1'b1);
        chk("R3 noise pulse no polarity", pol_reversed, 1'b0);
        send_data(1'b1);
        chk("R7 neg after noise", pol_reversed, 1'b1);
    endtask

    task automatic t_pol_disable;
        pol_fix_en = 1'b0;
        idle(1);
        chk("R8 cleared", pol_reversed, 1'b0);
        send_data(1'b1);
        send_data(1'b1);
        chk("R8 stays clear", pol_reversed, 1'b0);
        pol_fix_en = 1'b1;
        send_data(1'b1);
        chk("R8 run restarts", pol_reversed, 1'b0);
    endtask

    task automatic t_forced;
        idle(170);
        expect_link("R5 before force", 1'b1);
        auto_sel = 1'b0;
        idle(1);
        expect_link("R2 forced", 1'b0);
        idle(200);
        expect_link("R2 forced quiet", 1'b0);
        auto_sel = 1'b1;
        idle(1);
        expect_link("R2 leave force", 1'b0);
        idle(170);
        expect_link("R5 after force", 1'b1);
    endtask

    initial begin
        t_reset();
        t_first_pulse();
        t_loss();
        t_noise();
        t_data();
        t_polarity();
        t_pol_disable();
        t_forced();
        $display("== %0d vectors applied, %0d miscompares ==", total, miss);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        miss++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", total, miss);
        $finish;
    end
endmodule